// File: doc/BRIEF.md
# Ping-Pong Parity Write Feeder

This block turns host write requests into a stream of parity-tagged symbols. Each request names a start address and a byte count in a byte-wide memory. The block fetches those bytes, adds an odd parity bit to each one, and stages the 9-bit results in one of two staging buffers. Each buffer holds `STAGE_DEPTH` entries. While one buffer drains into the downstream symbol stream, the other is refilled from memory. Downstream therefore sees an unbroken stream across buffer swaps.

A request that starts at the end address of the transfer in progress is folded into it. While a transfer runs, one further non-contiguous request can wait in a single queue slot, and later contiguous requests are folded into that queued one. The queued transfer is promoted as soon as the active one has been fully fetched.

When every byte has been fetched and accepted downstream, the block moves to a distinct "feed done" phase rather than back to idle. The downstream bus logic may still be finishing its own handshake at that point. A registered query port reports whether a given address is still waiting to be fetched.

Top module: `parity_write_feeder`

## Requirements
- R1: During and directly after a synchronous active-high reset, `req_ready` is 1 and `sym_valid`, `feed_busy`, `feed_done` and `mem_rd_en` are 0.
- R2: Every output symbol carries the data byte in bits 7:0 and a parity bit in bit 8. The parity bit makes the number of ones across all nine bits odd.
- R3: Symbols come out in request-acceptance order, and within a request in ascending address order. Every accepted byte appears exactly once. A symbol held with `sym_ready` low keeps its value.
- R4: Each refill fetches at most `STAGE_DEPTH` bytes and never crosses from one request into the next. With downstream stalled, exactly `2*STAGE_DEPTH` bytes of a long transfer are fetched ahead, and no more.
- R5: While feeding with the queue slot empty, a request whose address equals the end of the active transfer is accepted at once and appended to it.
- R6: While feeding, a non-contiguous request is accepted into an empty queue slot. A request whose address equals the end of the queued transfer is accepted and appended to it.
- R7: While the queue slot holds a transfer, a request whose address differs from the queued end sees `req_ready` low. This holds even if its address equals the active end. Holding such a request changes no state.
- R8: Once every byte of the active transfer is fetched, the queued transfer becomes active and the queue slot frees, so a back-pressured request can then be accepted.
- R9: `feed_done` rises only when all accepted bytes have been delivered downstream. On that same edge `feed_busy` falls. A zero-length request accepted from idle reaches `feed_done` without emitting any symbol.
- R10: `qry_pending` is registered. One cycle after `qry_addr` is presented, it is 1 exactly when, during feeding, the address lies in the unfetched part of the active transfer or inside the queued transfer.
- R11: In idle or feed-done, `req_ready` is 1. An accepted request starts a fresh transfer, clears `feed_done` and raises `feed_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | First byte address of the request |
| req_len | input | LEN_W | Byte count of the request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| mem_rd_en | output | 1 | Byte memory read strobe |
| mem_rd_addr | output | ADDR_W | Byte memory read address |
| mem_rd_data | input | 8 | Byte returned one cycle after the strobe |
| sym_valid | output | 1 | Output symbol present |
| sym_ready | input | 1 | Downstream accepts the symbol |
| sym_data | output | 9 | Parity bit 8, data byte 7:0 |
| qry_addr | input | ADDR_W | Address to test for pending status |
| qry_pending | output | 1 | Registered: queried address still awaits fetch |
| feed_busy | output | 1 | A transfer is being fed |
| feed_done | output | 1 | All accepted data delivered downstream |

## Verification
The bench sweeps request lengths across the 4-entry staging size: one byte short of a buffer, exactly a buffer, a buffer plus one, two buffers plus one. It runs these under always-ready, alternating and pseudo-random downstream pacing. A design that mishandled the buffer swap would drop or repeat a symbol at the boundary. A design that split a refill wrongly would reorder bytes.

With downstream stalled, a contiguous/queued/contiguous-to-queue request chain is built. The bench then scans the query port across both transfer edges. An off-by-one in the fetch pointer, or a third buffer's worth of prefetch, would show up as a wrong pending bit. A request aimed at the active end while the queue is occupied must be refused; a design that merged it would emit bytes out of order.

A zero-length request and repeated starts from the feed-done phase catch a design that never leaves feeding, or that raises done while symbols are still in flight.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FEED = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  localparam int SYM_W = 9;

  // odd parity: bit 8 set when the byte holds an even number of ones
  function automatic logic [SYM_W-1:0] make_sym(input logic [7:0] b);
    return {~^b, b};
  endfunction

endpackage

// File: rtl/pwf_stage_ram.sv
module pwf_stage_ram #(
  parameter int ENTRIES = 512,
  parameter int DW      = 9,
  localparam int AW     = $clog2(ENTRIES)
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/pwf_req_track.sv
module pwf_req_track #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              feeding,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_n,
  output logic [ADDR_W-1:0] act_ptr,
  output logic [ADDR_W-1:0] act_left,
  output logic              q_valid,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_pending
);

  logic [ADDR_W-1:0] act_end, q_base, q_end, len_x;
  logic              fire, in_act, in_q;

  assign len_x     = ADDR_W'(req_len);
  assign req_ready = !feeding || !q_valid || (req_addr == q_end);
  assign fire      = req_valid && req_ready;
  assign act_left  = act_end - act_ptr;
  assign in_act    = (qry_addr >= act_ptr) && (qry_addr < act_end);
  assign in_q      = (qry_addr >= q_base) && (qry_addr < q_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_ptr     <= '0;
      act_end     <= '0;
      q_valid     <= 1'b0;
      q_base      <= '0;
      q_end       <= '0;
      qry_pending <= 1'b0;
    end else begin
      if (!feeding) begin
        if (fire) begin
          act_ptr <= req_addr;
          act_end <= req_addr + len_x;
          q_valid <= 1'b0;
        end
      end else begin
        if (take) act_ptr <= act_ptr + take_n;
        if (fire) begin
          if (!q_valid && req_addr == act_end) begin
            act_end <= act_end + len_x;
          end else if (q_valid) begin
            q_end <= q_end + len_x;
          end else begin
            q_valid <= 1'b1;
            q_base  <= req_addr;
            q_end   <= req_addr + len_x;
          end
        end else if (!take && act_ptr == act_end && q_valid) begin
          act_ptr <= q_base;
          act_end <= q_end;
          q_valid <= 1'b0;
        end
      end
      qry_pending <= feeding && (in_act || (q_valid && in_q));
    end
  end

endmodule

// File: rtl/pwf_refill.sv
module pwf_refill import pwf_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int STAGE_DEPTH = 256,
  localparam int IDX_W      = $clog2(STAGE_DEPTH),
  localparam int CNT_W      = $clog2(STAGE_DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_buf,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_cnt,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              wr_en,
  output logic [IDX_W:0]    wr_addr,
  output logic [SYM_W-1:0]  wr_data,
  output logic              done,
  output logic              done_buf,
  output logic [CNT_W-1:0]  done_cnt
);

  logic              issuing, buf_q, rd_vld, rd_last;
  logic [CNT_W-1:0]  total, issued;
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] addr_q;
  logic              last_issue;

  assign last_issue  = issued == total - 1'b1;
  assign mem_rd_en   = issuing;
  assign mem_rd_addr = addr_q;
  assign wr_en       = rd_vld;
  assign wr_addr     = {buf_q, rd_idx};
  assign wr_data     = make_sym(mem_rd_data);
  assign done        = rd_vld && rd_last;
  assign done_buf    = buf_q;
  assign done_cnt    = total;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      buf_q   <= 1'b0;
      total   <= '0;
      issued  <= '0;
      addr_q  <= '0;
      rd_vld  <= 1'b0;
      rd_last <= 1'b0;
      rd_idx  <= '0;
    end else begin
      rd_vld  <= issuing;
      rd_last <= issuing && last_issue;
      rd_idx  <= issued[IDX_W-1:0];
      if (start) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        buf_q   <= start_buf;
        total   <= start_cnt;
        issued  <= '0;
        addr_q  <= start_addr;
      end else if (issuing) begin
        addr_q <= addr_q + 1'b1;
        issued <= issued + 1'b1;
        if (last_issue) issuing <= 1'b0;
      end
      if (rd_vld && rd_last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/pwf_drain.sv
module pwf_drain import pwf_pkg::*; #(
  parameter int STAGE_DEPTH = 256,
  localparam int IDX_W      = $clog2(STAGE_DEPTH),
  localparam int CNT_W      = $clog2(STAGE_DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_done,
  input  logic             fill_buf,
  input  logic [CNT_W-1:0] fill_cnt,
  output logic             rd_en,
  output logic [IDX_W:0]   rd_addr,
  input  logic [SYM_W-1:0] rd_data,
  output logic             cur,
  output logic [1:0]       buf_rdy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             empty
);

  logic [CNT_W-1:0] cnt_q [2];
  logic [IDX_W-1:0] idx;
  logic             inflight;
  logic [1:0]       occ;
  logic [SYM_W-1:0] q0, q1;
  logic             pop, room, issue, last, oth;
  logic [2:0]       lvl;

  assign oth       = ~cur;
  assign pop       = (occ != 2'd0) && out_ready;
  assign lvl       = {1'b0, occ} + {2'b0, inflight};
  assign room      = lvl <= (3'd1 + {2'b0, pop});
  assign issue     = buf_rdy[cur] && room;
  assign last      = (CNT_W'(idx) + 1'b1) == cnt_q[cur];
  assign rd_en     = issue;
  assign rd_addr   = {cur, idx};
  assign out_valid = occ != 2'd0;
  assign out_data  = q0;
  assign empty     = (occ == 2'd0) && !inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) cnt_q[i] <= '0;
      buf_rdy  <= 2'b00;
      cur      <= 1'b0;
      idx      <= '0;
      inflight <= 1'b0;
      occ      <= 2'd0;
      q0       <= '0;
      q1       <= '0;
    end else begin
      inflight <= issue;
      if (fill_done) begin
        buf_rdy[fill_buf] <= 1'b1;
        cnt_q[fill_buf]   <= fill_cnt;
      end
      if (issue) begin
        if (last) begin
          idx          <= '0;
          buf_rdy[cur] <= 1'b0;
          if (buf_rdy[oth]) cur <= oth;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (!buf_rdy[cur] && buf_rdy[oth]) begin
        cur <= oth;
      end
      case ({inflight, pop})
        2'b10: begin
          if (occ == 2'd0) q0 <= rd_data;
          else             q1 <= rd_data;
          occ <= occ + 1'b1;
        end
        2'b01: begin
          q0  <= q1;
          occ <= occ - 1'b1;
        end
        2'b11: begin
          if (occ == 2'd1) q0 <= rd_data;
          else begin
            q0 <= q1;
            q1 <= rd_data;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/parity_write_feeder.sv
module parity_write_feeder import pwf_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 16,
  parameter int STAGE_DEPTH = 256
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [8:0]        sym_data,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_pending,
  output logic              feed_busy,
  output logic              feed_done
);

  localparam int IDX_W = $clog2(STAGE_DEPTH);
  localparam int CNT_W = $clog2(STAGE_DEPTH + 1);
  localparam int RAM_N = 2 * STAGE_DEPTH;

  phase_t            phase;
  logic              feeding, fire, q_valid;
  logic [ADDR_W-1:0] act_ptr, act_left;
  logic [CNT_W-1:0]  chunk;
  logic              fill_start, fill_busy, fill_done, fill_buf;
  logic [CNT_W-1:0]  fill_cnt;
  logic              ram_we, ram_re;
  logic [IDX_W:0]    ram_waddr, ram_raddr;
  logic [SYM_W-1:0]  ram_wdata, ram_rdata;
  logic              cur, drain_empty, finish;
  logic [1:0]        buf_rdy;

  assign feeding    = phase == PH_FEED;
  assign fire       = req_valid && req_ready;
  assign chunk      = (act_left >= ADDR_W'(STAGE_DEPTH)) ? CNT_W'(STAGE_DEPTH)
                                                         : CNT_W'(act_left);
  assign fill_start = feeding && !fill_busy && (act_left != '0) && !buf_rdy[~cur];
  assign finish     = feeding && !fire && (act_left == '0) && !q_valid &&
                      !fill_busy && (buf_rdy == 2'b00) && drain_empty;
  assign feed_busy  = feeding;
  assign feed_done  = phase == PH_DONE;

  always_ff @(posedge clk) begin
    if (rst)                  phase <= PH_IDLE;
    else if (!feeding && fire) phase <= PH_FEED;
    else if (finish)           phase <= PH_DONE;
  end

  pwf_req_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .feeding     (feeding),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_ready   (req_ready),
    .take        (fill_start),
    .take_n      (ADDR_W'(chunk)),
    .act_ptr     (act_ptr),
    .act_left    (act_left),
    .q_valid     (q_valid),
    .qry_addr    (qry_addr),
    .qry_pending (qry_pending)
  );

  pwf_refill #(.ADDR_W(ADDR_W), .STAGE_DEPTH(STAGE_DEPTH)) u_refill (
    .clk         (clk),
    .rst         (rst),
    .start       (fill_start),
    .start_buf   (~cur),
    .start_addr  (act_ptr),
    .start_cnt   (chunk),
    .busy        (fill_busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .wr_en       (ram_we),
    .wr_addr     (ram_waddr),
    .wr_data     (ram_wdata),
    .done        (fill_done),
    .done_buf    (fill_buf),
    .done_cnt    (fill_cnt)
  );

  pwf_stage_ram #(.ENTRIES(RAM_N), .DW(SYM_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  pwf_drain #(.STAGE_DEPTH(STAGE_DEPTH)) u_drain (
    .clk       (clk),
    .rst       (rst),
    .fill_done (fill_done),
    .fill_buf  (fill_buf),
    .fill_cnt  (fill_cnt),
    .rd_en     (ram_re),
    .rd_addr   (ram_raddr),
    .rd_data   (ram_rdata),
    .cur       (cur),
    .buf_rdy   (buf_rdy),
    .out_valid (sym_valid),
    .out_ready (sym_ready),
    .out_data  (sym_data),
    .empty     (drain_empty)
  );

endmodule

// File: rtl/pwf_checker.sv
module pwf_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       mem_rd_en,
  input logic       sym_valid,
  input logic       sym_ready,
  input logic [8:0] sym_data,
  input logic       feed_busy,
  input logic       feed_done
);

  // R1: outputs quiet in the cycle after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!sym_valid && !feed_busy && !feed_done && !mem_rd_en && req_ready));

  // R2: every presented symbol has odd parity across nine bits
  p_parity_odd_r2: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (^sym_data) == 1'b1);

  // R3: a stalled symbol stays put
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data)));

  // R9: nothing left downstream once done
  p_done_no_data_r9: assert property (@(posedge clk) disable iff (rst)
    feed_done |-> !sym_valid);

  // R9: phases exclusive
  p_phase_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(feed_busy && feed_done));

  // R11: outside feeding every request is taken
  p_idle_ready_r11: assert property (@(posedge clk) disable iff (rst)
    !feed_busy |-> req_ready);

endmodule

bind parity_write_feeder pwf_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_rd_en (mem_rd_en),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .sym_data  (sym_data),
  .feed_busy (feed_busy),
  .feed_done (feed_done)
);

// File: tb/sim_parity_write_feeder.sv
module sim_parity_write_feeder;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 12;
  localparam int LW    = 8;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_ready;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data = '0;
  logic          sym_valid;
  logic          sym_ready = 1'b0;
  logic [8:0]    sym_data;
  logic [AW-1:0] qry_addr = '0;
  logic          qry_pending;
  logic          feed_busy;
  logic          feed_done;

  int n_chk = 0;
  int n_bad = 0;
  int rmode = 1;
  bit ended = 1'b0;
  logic [8:0] exq [0:2047];
  int wp = 0;
  int rp = 0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_write_feeder #(.ADDR_W(AW), .LEN_W(LW), .STAGE_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .qry_addr(qry_addr), .qry_pending(qry_pending),
    .feed_busy(feed_busy), .feed_done(feed_done)
  );

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ {a[11:8], a[3:0]} ^ 8'h5A;
  endfunction

  function automatic logic [8:0] esym(input logic [7:0] b);
    logic p;
    p = ($countones(b) % 2) == 0;
    return {p, b};
  endfunction

  // byte memory model: one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mbyte(mem_rd_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // downstream pacing
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rmode)
      0: sym_ready = 1'b0;
      1: sym_ready = 1'b1;
      2: sym_ready = ~sym_ready;
      default: sym_ready = lfsr[0] | lfsr[3];
    endcase
  end

  // output monitor: R2, R3
  initial forever begin
    @(negedge clk);
    #2;
    if (!rst && sym_valid && sym_ready) begin
      if (rp >= wp) check(1'b0, "R3 extra symbol", sym_data, 0);
      else begin
        check(sym_data === exq[rp], "R2/R3 symbol", sym_data, exq[rp]);
        rp++;
      end
    end
  end

  task automatic send(input int a, input int l, output int waits);
    waits = 0;
    req_addr  = AW'(a);
    req_len   = LW'(l);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
      waits++;
    end
    for (int i = 0; i < l; i++) begin
      exq[wp] = esym(mbyte(AW'(a + i)));
      wp++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!feed_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    #3;
    check(feed_done === 1'b1, {tag, " R9 done"}, feed_done, 1);
    check(rp == wp, {tag, " R9 all delivered"}, rp, wp);
    check(feed_busy === 1'b0, {tag, " R9 busy low"}, feed_busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    bit exp_p;
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    check(sym_valid === 1'b0 && feed_busy === 1'b0 && feed_done === 1'b0, "R1 in reset",
          {sym_valid, feed_busy, feed_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(req_ready === 1'b1, "R1 ready", req_ready, 1);
    check(mem_rd_en === 1'b0 && sym_valid === 1'b0, "R1 quiet", {mem_rd_en, sym_valid}, 0);
    check(feed_busy === 1'b0 && feed_done === 1'b0, "R1 phase", {feed_busy, feed_done}, 0);
    @(negedge clk);

    // R9: zero-length request
    send(50, 0, w);
    wait_done("zero");
    @(negedge clk);

    // length sweep across buffer boundaries, three pacing modes (R3, R4, R11)
    for (int m = 1; m <= 3; m++) begin
      rmode = m;
      for (int l = 1; l <= 10; l++) begin
        send(16 * l + 200 * m, l, w);
        #1;
        check(feed_busy === 1'b1 && feed_done === 1'b0, "R11 fresh start",
              {feed_busy, feed_done}, 2);
        wait_done("sweep");
        @(negedge clk);
      end
      // non-contiguous pair: second waits in queue (R6, R8)
      send(900 + m * 40, 5, w);
      send(1500 + m * 40, 3, w);
      check(w == 0, "R6 queued accept", w, 0);
      wait_done("pair");
      @(negedge clk);
    end

    // merge and queue chain with downstream stalled
    rmode = 0;
    repeat (3) @(negedge clk);
    send(100, 6, w);
    send(106, 5, w);
    check(w == 0, "R5 merge into active", w, 0);
    send(300, 3, w);
    check(w == 0, "R6 queue slot", w, 0);
    send(303, 2, w);
    check(w == 0, "R6 merge into queue", w, 0);
    repeat (40) @(negedge clk);

    // R7: refused addresses, including the active end
    req_addr = AW'(500);
    #1;
    check(req_ready === 1'b0, "R7 non-contiguous refused", req_ready, 0);
    req_addr = AW'(111);
    #1;
    check(req_ready === 1'b0, "R7 active end refused", req_ready, 0);
    req_addr = AW'(305);
    #1;
    check(req_ready === 1'b1, "R6 queue end open", req_ready, 1);

    // R4/R10: exactly 2*DEPTH bytes fetched ahead; scan both transfers
    for (int qa = 95; qa < 116; qa++) begin
      qry_addr = AW'(qa);
      @(negedge clk);
      #1;
      exp_p = (qa >= 100 + 2 * DEPTH) && (qa < 111);
      check(qry_pending === exp_p, "R4/R10 active pending", qry_pending, exp_p);
    end
    for (int qa = 296; qa < 310; qa++) begin
      qry_addr = AW'(qa);
      @(negedge clk);
      #1;
      exp_p = (qa >= 300) && (qa < 305);
      check(qry_pending === exp_p, "R10 queued pending", qry_pending, exp_p);
    end

    // R7: holding a refused request changes nothing
    req_addr  = AW'(500);
    req_len   = LW'(1);
    req_valid = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(req_ready === 1'b0, "R7 still refused", req_ready, 0);
    req_valid = 1'b0;
    qry_addr  = AW'(500);
    @(negedge clk);
    #1;
    check(qry_pending === 1'b0, "R7 no effect on state", qry_pending, 0);
    qry_addr  = AW'(304);
    @(negedge clk);
    #1;
    check(qry_pending === 1'b1, "R7 queue intact", qry_pending, 1);
    check(rp == 0 || sym_valid === 1'b1, "R3 stalled", rp, 0);

    // R8: release downstream; refused request gets in after promotion
    rmode = 1;
    send(500, 1, w);
    check(w > 0, "R8 accepted after promotion", w, 1);
    wait_done("chain");
    qry_addr = AW'(102);
    @(negedge clk);
    #1;
    check(qry_pending === 1'b0, "R10 not pending when done", qry_pending, 0);

    // R11: restart from done with paced downstream
    rmode = 3;
    send(700, 9, w);
    #1;
    check(feed_done === 1'b0, "R11 done clears", feed_done, 0);
    wait_done("restart");

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule